// File: doc/BRIEF.md
# Condition Flag Manipulation Unit

This unit holds the four condition flags (negative, zero, carry, overflow) and executes a small family of instructions that touch only those flags. It can invert the carry, convert between two flag conventions in either direction, load any subset of the flags from a rotated 64-bit operand, and derive flags from the low 8 or 16 bits of an operand. The register operand comes from outside; the unit does not read a register file.

An instruction word is presented together with an issue strobe. The unit decodes it from two encoding groups, the flag-only immediate group and the carry-arithmetic group, and commits the new flags on the next clock edge. If the base feature is switched off, or the encoding is reserved, it raises a one-cycle undefined-instruction pulse and leaves the flags alone. A 2-bit feature-level field reports which of the two feature levels is enabled.

Flags are exposed as `flags_q[3]`=N, `flags_q[2]`=Z, `flags_q[1]`=C, `flags_q[0]`=V.

Top module: `cond_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears `flags_q` to 0000 and `undef_pulse` to 0.
- R2: Carry-invert complements C and keeps N, Z and V.
- R3: Architectural-to-external conversion gives Z = Z|V, C = C&~V, N = 0, V = 0.
- R4: External-to-architectural conversion, from the old C and Z, gives N = ~C&~Z, Z = C&Z, C = C|Z, V = ~C&Z.
- R5: The flag-only immediate group is matched when bits 31:19 = 1101010100000, bits 15:12 = 0100 and bits 4:0 = 11111. Its selector {bits 18:16, bits 7:5} picks carry-invert at 0, external-to-architectural at 1 and architectural-to-external at 2. Any other selector changes nothing and raises no pulse.
- R6: The carry-arithmetic group is matched when bits 28:21 = 11010000. In it, bits 11:10 = 01 is rotate-into-flags. The operand is rotated right by bits 20:15. Mask bit i (bits 3:0) loads flag bit i from bit i of the rotated value (bit 0 V, 1 C, 2 Z, 3 N). Flags whose mask bit is clear keep their value.
- R7: In the same group, bits 11:10 = 10 is evaluate-into-flags. Bit 14 selects the top index t: 7 when 0, 15 when 1. N becomes operand bit t, Z becomes 1 exactly when bits t..0 are all zero, V becomes bit t XOR bit t+1, and C is kept.
- R8: In the same group, bits 11:10 = 11 is undefined and raises the pulse with no flag change. Bits 11:10 = 00 changes nothing and raises no pulse.
- R9: With `feat_base_en` low, each of the five flag operations raises the pulse instead of changing the flags.
- R10: `feat_level` is 2 when `feat_ext_en` is high, otherwise 1 when `feat_base_en` is high, otherwise 0.
- R11: Flags change only on the clock edge after a cycle with `issue_valid` high. `undef_pulse` is high for exactly the one cycle after each offending issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| src_operand | input | 64 | Register operand for rotate and evaluate |
| feat_base_en | input | 1 | Base flag-manipulation level enabled |
| feat_ext_en | input | 1 | Second feature level enabled |
| flags_q | output | 4 | Flags {N,Z,C,V} |
| undef_pulse | output | 1 | One-cycle undefined-instruction indication |
| feat_level | output | 2 | Feature-level ID field |

## Verification
The flags and the undefined pulse both come from one register stage. They are due at the first rising edge after the issue cycle, and the pulse must be gone one edge later. The feature-level field is combinational and is due in the same cycle as its enables. The bench drives each instruction on a falling edge and holds it for one cycle. It samples flags and pulse on the next falling edge, samples the pulse once more a cycle later, and reads the feature field a short delay after changing the enables.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_CFINV, OP_A2X, OP_X2A, OP_RMIF, OP_SETF, OP_BAD
  } cfu_op_e;

  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_C = 1;
  localparam int FLG_V = 0;

  function automatic logic [3:0] f_cfinv(input logic [3:0] f);
    f_cfinv = {f[FLG_N], f[FLG_Z], ~f[FLG_C], f[FLG_V]};
  endfunction

  function automatic logic [3:0] f_a2x(input logic [3:0] f);
    f_a2x = {1'b0, f[FLG_Z] | f[FLG_V], f[FLG_C] & ~f[FLG_V], 1'b0};
  endfunction

  function automatic logic [3:0] f_x2a(input logic [3:0] f);
    logic c, z;
    c = f[FLG_C];
    z = f[FLG_Z];
    f_x2a = {~c & ~z, c & z, c | z, ~c & z};
  endfunction

  function automatic logic [3:0] f_insert(input logic [3:0] f, input logic [3:0] nib,
                                          input logic [3:0] mask);
    f_insert = (f & ~mask) | (nib & mask);
  endfunction

  function automatic logic [3:0] f_eval(input logic [3:0] f, input logic top,
                                        input logic above, input logic low_zero);
    f_eval = {top, low_zero, f[FLG_C], top ^ above};
  endfunction
endpackage

// File: rtl/cfu_decode.sv
module cfu_decode
  import cfu_pkg::*;
#(
  parameter int ILEN  = 32,
  parameter int AMT_W = 6
) (
  input  logic [ILEN-1:0]  instr,
  input  logic             base_en,
  output cfu_op_e          op,
  output logic             undef_req,
  output logic [AMT_W-1:0] rot_amt,
  output logic [3:0]       rot_mask,
  output logic             eval_wide
);
  logic       grp_imm, grp_carry;
  logic [5:0] imm_sel;
  logic       is_flag_op;

  assign grp_imm   = (instr[31:19] == 13'b1101010100000) &&
                     (instr[15:12] == 4'b0100) && (instr[4:0] == 5'b11111);
  assign grp_carry = (instr[28:21] == 8'b11010000);
  assign imm_sel   = {instr[18:16], instr[7:5]};

  always_comb begin
    op = OP_NONE;
    if (grp_imm) begin
      case (imm_sel)
        6'd0:    op = OP_CFINV;
        6'd1:    op = OP_X2A;
        6'd2:    op = OP_A2X;
        default: op = OP_NONE;
      endcase
    end else if (grp_carry) begin
      case (instr[11:10])
        2'b01:   op = OP_RMIF;
        2'b10:   op = OP_SETF;
        2'b11:   op = OP_BAD;
        default: op = OP_NONE;
      endcase
    end
  end

  assign is_flag_op = (op == OP_CFINV) || (op == OP_A2X) || (op == OP_X2A) ||
                      (op == OP_RMIF) || (op == OP_SETF);
  assign undef_req  = (op == OP_BAD) || (is_flag_op && !base_en);
  assign rot_amt    = instr[15 +: AMT_W];
  assign rot_mask   = instr[3:0];
  assign eval_wide  = instr[14];
endmodule

// File: rtl/cfu_exec.sv
module cfu_exec
  import cfu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int AMT_W = $clog2(XLEN)
) (
  input  cfu_op_e          op,
  input  logic [3:0]       flags_cur,
  input  logic [XLEN-1:0]  src,
  input  logic [AMT_W-1:0] rot_amt,
  input  logic [3:0]       rot_mask,
  input  logic             eval_wide,
  output logic [3:0]       flags_nxt
);
  localparam int NARROW_TOP = 7;
  localparam int WIDE_TOP   = 15;

  logic [XLEN-1:0] rotated;
  logic            ev_top, ev_above, ev_zero;

  always_comb begin
    rotated = '0;
    for (int i = 0; i < XLEN; i++)
      rotated[i] = src[(i + int'(rot_amt)) % XLEN];
  end

  always_comb begin
    if (eval_wide) begin
      ev_top   = src[WIDE_TOP];
      ev_above = src[WIDE_TOP+1];
      ev_zero  = (src[WIDE_TOP:0] == '0);
    end else begin
      ev_top   = src[NARROW_TOP];
      ev_above = src[NARROW_TOP+1];
      ev_zero  = (src[NARROW_TOP:0] == '0);
    end
  end

  always_comb begin
    case (op)
      OP_CFINV: flags_nxt = f_cfinv(flags_cur);
      OP_A2X:   flags_nxt = f_a2x(flags_cur);
      OP_X2A:   flags_nxt = f_x2a(flags_cur);
      OP_RMIF:  flags_nxt = f_insert(flags_cur, rotated[3:0], rot_mask);
      OP_SETF:  flags_nxt = f_eval(flags_cur, ev_top, ev_above, ev_zero);
      default:  flags_nxt = flags_cur;
    endcase
  end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cfu_pkg::*;
#(
  parameter int ILEN = 32,
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_valid,
  input  logic [ILEN-1:0] instr,
  input  logic [XLEN-1:0] src_operand,
  input  logic            feat_base_en,
  input  logic            feat_ext_en,
  output logic [3:0]      flags_q,
  output logic            undef_pulse,
  output logic [1:0]      feat_level
);
  localparam int AMT_W = $clog2(XLEN);

  cfu_op_e          op_kind;
  logic             undef_req;
  logic [AMT_W-1:0] rot_amt;
  logic [3:0]       rot_mask;
  logic             eval_wide;
  logic [3:0]       flags_nxt;
  logic             commit_en;
  logic             undef_set;

  cfu_decode #(.ILEN(ILEN), .AMT_W(AMT_W)) u_dec (
    .instr(instr), .base_en(feat_base_en), .op(op_kind), .undef_req(undef_req),
    .rot_amt(rot_amt), .rot_mask(rot_mask), .eval_wide(eval_wide)
  );

  cfu_exec #(.XLEN(XLEN), .AMT_W(AMT_W)) u_exe (
    .op(op_kind), .flags_cur(flags_q), .src(src_operand), .rot_amt(rot_amt),
    .rot_mask(rot_mask), .eval_wide(eval_wide), .flags_nxt(flags_nxt)
  );

  assign commit_en = issue_valid && !undef_req && (op_kind != OP_NONE);
  assign undef_set = issue_valid && undef_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q     <= 4'b0000;
      undef_pulse <= 1'b0;
    end else begin
      if (commit_en) flags_q <= flags_nxt;
      undef_pulse <= undef_set;
    end
  end

  always_comb begin
    if (feat_ext_en)       feat_level = 2'd2;
    else if (feat_base_en) feat_level = 2'd1;
    else                   feat_level = 2'd0;
  end
endmodule

// File: rtl/cond_flag_unit_chk.sv
module cond_flag_unit_chk
  import cfu_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       issue_valid,
  input logic       feat_base_en,
  input logic       feat_ext_en,
  input logic [3:0] flags_q,
  input logic       undef_pulse,
  input logic [1:0] feat_level,
  input cfu_op_e    op_kind,
  input logic       undef_req
);
  a_r1_reset_clear: assert property (@(posedge clk) $past(rst) |-> (flags_q == 4'b0000 && !undef_pulse));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(issue_valid)) |-> (flags_q == $past(flags_q) && !undef_pulse));

  a_r9_undef_no_change: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && undef_pulse) |-> flags_q == $past(flags_q));

  a_r2_cfinv: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(issue_valid) && $past(op_kind) == OP_CFINV && !$past(undef_req))
      |-> flags_q == ($past(flags_q) ^ 4'b0010));

  a_r3_a2x_clears_nv: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(issue_valid) && $past(op_kind) == OP_A2X && !$past(undef_req))
      |-> (!flags_q[3] && !flags_q[0]));

  a_r7_eval_keeps_c: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(issue_valid) && $past(op_kind) == OP_SETF)
      |-> flags_q[1] == $past(flags_q[1]));

  a_r8_bad_raises: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(issue_valid) && $past(op_kind) == OP_BAD) |-> undef_pulse);

  a_r10_level: assert property (@(posedge clk) disable iff (rst)
    feat_ext_en |-> feat_level == 2'd2);
endmodule

bind cond_flag_unit cond_flag_unit_chk u_chk (
  .clk(clk), .rst(rst), .issue_valid(issue_valid), .feat_base_en(feat_base_en),
  .feat_ext_en(feat_ext_en), .flags_q(flags_q), .undef_pulse(undef_pulse),
  .feat_level(feat_level), .op_kind(op_kind), .undef_req(undef_req)
);

// File: tb/cond_flag_unit_tb.sv
`timescale 1ns/1ps
module cond_flag_unit_tb;
  logic        clk = 0;
  logic        rst;
  logic        issue_valid;
  logic [31:0] instr;
  logic [63:0] src_operand;
  logic        feat_base_en, feat_ext_en;
  logic [3:0]  flags_q;
  logic        undef_pulse;
  logic [1:0]  feat_level;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] I_CFINV = 32'hD500401F;
  localparam logic [31:0] I_X2A   = 32'hD500403F;
  localparam logic [31:0] I_A2X   = 32'hD500405F;
  localparam logic [31:0] I_CARRY = 32'hBA000000;

  always #5 clk = ~clk;

  cond_flag_unit u_dut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .instr(instr),
    .src_operand(src_operand), .feat_base_en(feat_base_en), .feat_ext_en(feat_ext_en),
    .flags_q(flags_q), .undef_pulse(undef_pulse), .feat_level(feat_level)
  );

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_rmif(input int amt, input logic [3:0] mask);
    return I_CARRY | (32'(amt) << 15) | (32'd1 << 10) | 32'(mask);
  endfunction

  function automatic logic [31:0] mk_setf(input bit wide);
    return I_CARRY | (32'd2 << 10) | (32'(wide) << 14) | 32'hD;
  endfunction

  // issue one instruction, check flags and pulse one edge later, pulse gone after
  task automatic run_op(input string req, input logic [31:0] ins, input logic [63:0] opd,
                        input logic [3:0] exp_f, input bit exp_u);
    @(negedge clk);
    instr = ins; src_operand = opd; issue_valid = 1;
    @(negedge clk);
    issue_valid = 0;
    chk(req, flags_q, exp_f);
    chk(req, {3'b0, undef_pulse}, {3'b0, exp_u});
    @(negedge clk);
    chk(req, {3'b0, undef_pulse}, 4'b0);
    chk(req, flags_q, exp_f);
  endtask

  task automatic load_flags(input logic [3:0] f);
    run_op("R6", mk_rmif(0, 4'hF), {60'd0, f}, f, 0);
  endtask

  task automatic t_reset;
    chk("R1", flags_q, 4'b0000);
    chk("R1", {3'b0, undef_pulse}, 4'b0);
  endtask

  task automatic t_cfinv;
    load_flags(4'b1101);
    run_op("R2", I_CFINV, 0, 4'b1111, 0);
    run_op("R2", I_CFINV, 0, 4'b1101, 0);
  endtask

  task automatic t_a2x;
    load_flags(4'b1011); run_op("R3", I_A2X, 0, 4'b0100, 0);
    load_flags(4'b0010); run_op("R3", I_A2X, 0, 4'b0010, 0);
  endtask

  task automatic t_x2a;
    load_flags(4'b1001); run_op("R4", I_X2A, 0, 4'b1000, 0);
    load_flags(4'b0100); run_op("R4", I_X2A, 0, 4'b0011, 0);
    load_flags(4'b0110); run_op("R4", I_X2A, 0, 4'b0110, 0);
    load_flags(4'b0010); run_op("R4", I_X2A, 0, 4'b0010, 0);
  endtask

  task automatic t_sel_other;
    load_flags(4'b1010);
    run_op("R5", I_CFINV | 32'h60, 0, 4'b1010, 0);   // selector 3
    run_op("R5", I_CFINV | 32'h10000, 0, 4'b1010, 0); // selector 8
  endtask

  function automatic logic [3:0] ref_rot(input logic [63:0] v, input int amt);
    logic [127:0] d;
    d = {v, v} >> amt;
    return d[3:0];
  endfunction

  task automatic t_rmif;
    logic [3:0] n;
    load_flags(4'b0000);
    run_op("R6", mk_rmif(4, 4'hF), 64'hA0, ref_rot(64'hA0, 4), 0);
    load_flags(4'b0000);
    n = ref_rot(64'hF000_0000_0000_0000, 60);
    run_op("R6", mk_rmif(60, 4'b0101), 64'hF000_0000_0000_0000, n & 4'b0101, 0);
    load_flags(4'b1111);
    run_op("R6", mk_rmif(63, 4'b1010), 64'h1, 4'b0111, 0);
  endtask

  task automatic t_setf;
    load_flags(4'b0010);
    run_op("R7", mk_setf(0), 64'h80, 4'b1011, 0);
    run_op("R7", mk_setf(0), 64'h100, 4'b0111, 0);
    load_flags(4'b0000);
    run_op("R7", mk_setf(0), 64'h7F, 4'b0000, 0);
    run_op("R7", mk_setf(1), 64'h8000, 4'b1001, 0);
    run_op("R7", mk_setf(1), 64'h10000, 4'b0101, 0);
  endtask

  task automatic t_subops;
    load_flags(4'b0110);
    run_op("R8", I_CARRY | (32'd3 << 10), 64'hF, 4'b0110, 1);
    run_op("R8", I_CARRY, 64'hF, 4'b0110, 0);
  endtask

  task automatic t_disabled;
    load_flags(4'b1001);
    feat_base_en = 0;
    run_op("R9", I_CFINV, 0, 4'b1001, 1);
    run_op("R9", I_A2X, 0, 4'b1001, 1);
    run_op("R9", I_X2A, 0, 4'b1001, 1);
    run_op("R9", mk_rmif(0, 4'hF), 64'h6, 4'b1001, 1);
    run_op("R9", mk_setf(0), 64'h0, 4'b1001, 1);
    feat_base_en = 1;
  endtask

  task automatic t_level;
    feat_base_en = 0; feat_ext_en = 0; #1; chk("R10", {2'b0, feat_level}, 4'd0);
    feat_base_en = 1; feat_ext_en = 0; #1; chk("R10", {2'b0, feat_level}, 4'd1);
    feat_base_en = 1; feat_ext_en = 1; #1; chk("R10", {2'b0, feat_level}, 4'd2);
  endtask

  task automatic t_idle_and_pulse;
    load_flags(4'b0101);
    @(negedge clk);
    instr = I_CFINV; issue_valid = 0;
    @(negedge clk);
    chk("R11", flags_q, 4'b0101);
    @(negedge clk);
    instr = I_CARRY | (32'd3 << 10); issue_valid = 1;
    @(negedge clk);
    chk("R11", {3'b0, undef_pulse}, 4'b1);
    @(negedge clk);
    issue_valid = 0;
    chk("R11", {3'b0, undef_pulse}, 4'b1);
    @(negedge clk);
    chk("R11", {3'b0, undef_pulse}, 4'b0);
    chk("R11", flags_q, 4'b0101);
  endtask

  initial begin
    rst = 1; issue_valid = 0; instr = 0; src_operand = 0;
    feat_base_en = 1; feat_ext_en = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_cfinv();
    t_a2x();
    t_x2a();
    t_sel_other();
    t_rmif();
    t_setf();
    t_subops();
    t_disabled();
    t_level();
    t_idle_and_pulse();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule